// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two 8-input priority interrupt cores, a master and a slave, into one 16-source system. Both cores live outside the block and connect through ports. The slave core's interrupt output is routed straight into master input 2, and the master's output becomes the processor's interrupt line.

When the processor acknowledges an interrupt, the sequencer reads the master's current winner. If that winner is an ordinary line, the block acknowledges the master only. If the winner is the cascade line (line 2), it also acknowledges the slave. In either case it builds an 8-bit vector from the right controller's vector base and line number. When no request is pending, it returns a spurious vector instead.

The block also holds the two per-controller trigger-mode (edge/level) registers, each with its own fixed mask of writable bits. It also turns a poll that resolves on the slave into a strobe that clears master line 2 in the master core.

Top module: `cascade_ack_seq`

## Requirements
- R1: `mstCascadeIn` equals `slvIntReq` and `cpuIntr` equals `mstIntReq` in the same cycle, with no register on the way.
- R2: An accepted acknowledge whose master winner line is not 2 (and `mstPending`=1) gives `vector` = {`mstBase`, `mstLine`}, `mstAckStb`=1 with `mstAckLine`=`mstLine`, and `slvAckStb`=0.
- R3: An accepted acknowledge with master winner line 2 and `slvPending`=1 pulses `mstAckStb` with `mstAckLine`=2 and `slvAckStb` with `slvAckLine`=`slvLine`, and gives `vector` = {`slvBase`, `slvLine`}.
- R4: An accepted acknowledge with master winner line 2 and `slvPending`=0 gives the spurious slave vector {`slvBase`, 3'd7}. It pulses `mstAckStb` on line 2 and leaves `slvAckStb` at 0.
- R5: An accepted acknowledge with `mstPending`=0 gives the spurious master vector {`mstBase`, 3'd7}, with both `mstAckStb` and `slvAckStb` at 0.
- R6: `vectorValid` and the acknowledge strobes are registered. They rise on the clock edge that samples an accepted `cpuAck` and last exactly one cycle.
- R7: A `cpuAck` sampled while `vectorValid` is 1 is ignored: no vector, no strobe.
- R8: A write (`cfgWrEn`=1) with `cfgSel`=0 loads `mstTrigMode` with `cfgData` AND 0xF8. With `cfgSel`=1 it loads `slvTrigMode` with `cfgData` AND 0xDE. The other register keeps its value, and the new value shows on the cycle after the write.
- R9: `pollSlvHit` high at a clock edge makes `mstCascadeClr` high for the following cycle.
- R10: After reset, `vectorValid`, both strobes, `mstCascadeClr` and both trigger-mode registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slvIntReq | input | 1 | Interrupt output of the slave core |
| mstIntReq | input | 1 | Interrupt output of the master core |
| mstCascadeIn | output | 1 | Drives master core input 2 |
| cpuIntr | output | 1 | Interrupt line to the processor |
| cpuAck | input | 1 | Processor acknowledge request |
| mstPending | input | 1 | Master core has a winning request |
| mstLine | input | 3 | Master core winning line |
| slvPending | input | 1 | Slave core has a winning request |
| slvLine | input | 3 | Slave core winning line |
| mstBase | input | 5 | Master vector base (upper bits) |
| slvBase | input | 5 | Slave vector base (upper bits) |
| mstAckStb | output | 1 | Acknowledge strobe to master core |
| mstAckLine | output | 3 | Line acknowledged on master |
| slvAckStb | output | 1 | Acknowledge strobe to slave core |
| slvAckLine | output | 3 | Line acknowledged on slave |
| vector | output | 8 | Interrupt vector |
| vectorValid | output | 1 | One-cycle vector qualifier |
| cfgWrEn | input | 1 | Trigger-mode register write enable |
| cfgSel | input | 1 | 0 selects master register, 1 selects slave |
| cfgData | input | 8 | Write data |
| mstTrigMode | output | 8 | Master trigger-mode register |
| slvTrigMode | output | 8 | Slave trigger-mode register |
| pollSlvHit | input | 1 | A poll resolved on the slave core |
| mstCascadeClr | output | 1 | Clear master line 2 in-service and request bits |

## Verification
An acknowledge, a trigger-mode register write and a slave poll can all land on the same clock edge. They share that edge but touch separate state. The bench drives all three in one cycle and expects the vector, the masked register value and the clear strobe exactly as if each had been driven alone. A held acknowledge is also aimed at the cycle where `vectorValid` is high, to show the second request is dropped and the third is served.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
  typedef struct packed {
    logic load;
    logic mstAck;
    logic slvAck;
    logic useSlave;
    logic spurious;
  } ackCmd_t;
endpackage

// File: rtl/cascade_ack_ctrl.sv
module cascade_ack_ctrl
  import cascade_ack_pkg::*;
#(
  parameter int LINE_W       = 3,
  parameter int CASCADE_LINE = 2
) (
  input  logic              cpuAck,
  input  logic              busy,
  input  logic              mstPending,
  input  logic [LINE_W-1:0] mstLine,
  input  logic              slvPending,
  output ackCmd_t           cmd
);
  logic accept;
  logic viaCascade;

  always_comb begin
    accept       = cpuAck && !busy;
    viaCascade   = mstPending && (mstLine == LINE_W'(CASCADE_LINE));
    cmd.load     = accept;
    cmd.mstAck   = accept && mstPending;
    cmd.slvAck   = accept && viaCascade && slvPending;
    cmd.useSlave = viaCascade;
    cmd.spurious = !mstPending || (viaCascade && !slvPending);
  end
endmodule

// File: rtl/cascade_ack_dp.sv
module cascade_ack_dp
  import cascade_ack_pkg::*;
#(
  parameter int LINES        = 8,
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2,
  parameter logic [LINES-1:0] MST_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLV_MASK = 8'hDE,
  localparam int LINE_W = $clog2(LINES),
  localparam int BASE_W = VEC_W - LINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ackCmd_t           cmd,
  input  logic [LINE_W-1:0] mstLine,
  input  logic [LINE_W-1:0] slvLine,
  input  logic [BASE_W-1:0] mstBase,
  input  logic [BASE_W-1:0] slvBase,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [LINES-1:0]  cfgData,
  input  logic              pollSlvHit,
  output logic              mstAckStb,
  output logic [LINE_W-1:0] mstAckLine,
  output logic              slvAckStb,
  output logic [LINE_W-1:0] slvAckLine,
  output logic [VEC_W-1:0]  vector,
  output logic              vectorValid,
  output logic [LINES-1:0]  mstTrigMode,
  output logic [LINES-1:0]  slvTrigMode,
  output logic              mstCascadeClr
);
  localparam logic [LINES-1:0] MASKS [2] = '{MST_MASK, SLV_MASK};

  logic [LINE_W-1:0] vecLine;
  logic [BASE_W-1:0] vecBase;
  logic [LINES-1:0]  trig [2];

  always_comb begin
    vecBase = cmd.useSlave ? slvBase : mstBase;
    vecLine = cmd.spurious ? '1 : (cmd.useSlave ? slvLine : mstLine);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vectorValid   <= 1'b0;
      vector        <= '0;
      mstAckStb     <= 1'b0;
      slvAckStb     <= 1'b0;
      mstAckLine    <= '0;
      slvAckLine    <= '0;
      mstCascadeClr <= 1'b0;
    end else begin
      vectorValid   <= cmd.load;
      mstAckStb     <= cmd.mstAck;
      slvAckStb     <= cmd.slvAck;
      mstCascadeClr <= pollSlvHit;
      if (cmd.load) begin
        vector     <= {vecBase, vecLine};
        mstAckLine <= mstLine;
        slvAckLine <= slvLine;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gTrig
    always_ff @(posedge clk) begin
      if (!rstN)
        trig[g] <= '0;
      else if (cfgWrEn && cfgSel == 1'(g))
        trig[g] <= cfgData & MASKS[g];
    end

    assert_trig_write_R8: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWrEn && cfgSel == 1'(g)) |=> (trig[g] == ($past(cfgData) & MASKS[g])));
  end

  assign mstTrigMode = trig[0];
  assign slvTrigMode = trig[1];

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |=> !vectorValid);

  assert_slave_needs_master_R3: assert property (@(posedge clk) disable iff (!rstN)
    slvAckStb |-> (mstAckStb && mstAckLine == LINE_W'(CASCADE_LINE)));

  assert_strobe_with_vector_R5: assert property (@(posedge clk) disable iff (!rstN)
    mstAckStb |-> vectorValid);

  assert_poll_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    pollSlvHit |=> mstCascadeClr);
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import cascade_ack_pkg::*;
#(
  parameter int LINES        = 8,
  parameter int VEC_W        = 8,
  parameter int CASCADE_LINE = 2,
  parameter logic [LINES-1:0] MST_MASK = 8'hF8,
  parameter logic [LINES-1:0] SLV_MASK = 8'hDE,
  localparam int LINE_W = $clog2(LINES),
  localparam int BASE_W = VEC_W - LINE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slvIntReq,
  input  logic              mstIntReq,
  output logic              mstCascadeIn,
  output logic              cpuIntr,
  input  logic              cpuAck,
  input  logic              mstPending,
  input  logic [LINE_W-1:0] mstLine,
  input  logic              slvPending,
  input  logic [LINE_W-1:0] slvLine,
  input  logic [BASE_W-1:0] mstBase,
  input  logic [BASE_W-1:0] slvBase,
  output logic              mstAckStb,
  output logic [LINE_W-1:0] mstAckLine,
  output logic              slvAckStb,
  output logic [LINE_W-1:0] slvAckLine,
  output logic [VEC_W-1:0]  vector,
  output logic              vectorValid,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [LINES-1:0]  cfgData,
  output logic [LINES-1:0]  mstTrigMode,
  output logic [LINES-1:0]  slvTrigMode,
  input  logic              pollSlvHit,
  output logic              mstCascadeClr
);
  ackCmd_t cmd;

  assign mstCascadeIn = slvIntReq;
  assign cpuIntr      = mstIntReq;

  cascade_ack_ctrl #(.LINE_W(LINE_W), .CASCADE_LINE(CASCADE_LINE)) uCtrl (
    .cpuAck(cpuAck), .busy(vectorValid), .mstPending(mstPending),
    .mstLine(mstLine), .slvPending(slvPending), .cmd(cmd)
  );

  cascade_ack_dp #(
    .LINES(LINES), .VEC_W(VEC_W), .CASCADE_LINE(CASCADE_LINE),
    .MST_MASK(MST_MASK), .SLV_MASK(SLV_MASK)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .mstLine(mstLine), .slvLine(slvLine),
    .mstBase(mstBase), .slvBase(slvBase), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .pollSlvHit(pollSlvHit), .mstAckStb(mstAckStb),
    .mstAckLine(mstAckLine), .slvAckStb(slvAckStb), .slvAckLine(slvAckLine),
    .vector(vector), .vectorValid(vectorValid), .mstTrigMode(mstTrigMode),
    .slvTrigMode(slvTrigMode), .mstCascadeClr(mstCascadeClr)
  );

  assert_ack_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAck && !vectorValid) |=> vectorValid);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    vectorValid |=> (!mstAckStb && !slvAckStb));
endmodule

// File: tb/cascade_ack_seq_test.sv
module cascade_ack_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slvIntReq = 0, mstIntReq = 0, cpuAck = 0;
  logic mstPending = 0, slvPending = 0;
  logic [2:0] mstLine = 0, slvLine = 0;
  logic [4:0] mstBase = 0, slvBase = 0;
  logic cfgWrEn = 0, cfgSel = 0, pollSlvHit = 0;
  logic [7:0] cfgData = 0;
  logic mstCascadeIn, cpuIntr, mstAckStb, slvAckStb, vectorValid, mstCascadeClr;
  logic [2:0] mstAckLine, slvAckLine;
  logic [7:0] vector, mstTrigMode, slvTrigMode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cascade_ack_seq uut (
    .clk(clk), .rstN(rstN), .slvIntReq(slvIntReq), .mstIntReq(mstIntReq),
    .mstCascadeIn(mstCascadeIn), .cpuIntr(cpuIntr), .cpuAck(cpuAck),
    .mstPending(mstPending), .mstLine(mstLine), .slvPending(slvPending),
    .slvLine(slvLine), .mstBase(mstBase), .slvBase(slvBase),
    .mstAckStb(mstAckStb), .mstAckLine(mstAckLine), .slvAckStb(slvAckStb),
    .slvAckLine(slvAckLine), .vector(vector), .vectorValid(vectorValid),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .mstTrigMode(mstTrigMode), .slvTrigMode(slvTrigMode),
    .pollSlvHit(pollSlvHit), .mstCascadeClr(mstCascadeClr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one acknowledge and check the result on the following cycle.
  task automatic doAck(input bit mp, input logic [2:0] ml, input bit sp, input logic [2:0] sl);
    logic [7:0] expVec;
    bit expM, expS;
    string tag;
    @(negedge clk);
    mstPending = mp; mstLine = ml; slvPending = sp; slvLine = sl; cpuAck = 1;
    @(negedge clk);
    cpuAck = 0;
    expM = 0; expS = 0;
    if (!mp) begin
      expVec = {mstBase, 3'd7}; tag = "R5";
    end else if (ml != 3'd2) begin
      expVec = {mstBase, ml}; expM = 1; tag = "R2";
    end else if (sp) begin
      expVec = {slvBase, sl}; expM = 1; expS = 1; tag = "R3";
    end else begin
      expVec = {slvBase, 3'd7}; expM = 1; tag = "R4";
    end
    chk({tag, " vectorValid"}, 32'(vectorValid), 1);
    chk({tag, " vector"}, 32'(vector), 32'(expVec));
    chk({tag, " mstAckStb"}, 32'(mstAckStb), 32'(expM));
    chk({tag, " slvAckStb"}, 32'(slvAckStb), 32'(expS));
    if (expM) chk({tag, " mstAckLine"}, 32'(mstAckLine), 32'(ml));
    if (expS) chk({tag, " slvAckLine"}, 32'(slvAckLine), 32'(sl));
    @(negedge clk);
    chk("R6 valid pulse ends", 32'(vectorValid), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 vectorValid", 32'(vectorValid), 0);
    chk("R10 strobes", 32'({mstAckStb, slvAckStb, mstCascadeClr}), 0);
    chk("R10 trig", 32'({mstTrigMode, slvTrigMode}), 0);
    rstN = 1;

    // R1: combinational forwarding
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      slvIntReq = i[0]; mstIntReq = i[1];
      #1;
      chk("R1 cascade in", 32'(mstCascadeIn), 32'(i[0]));
      chk("R1 cpu intr", 32'(cpuIntr), 32'(i[1]));
    end

    // R2..R6: exhaustive acknowledge sweep over two base pairs
    for (int b = 0; b < 2; b++) begin
      mstBase = b ? 5'h1E : 5'h01;
      slvBase = b ? 5'h03 : 5'h1C;
      for (int mp = 0; mp < 2; mp++)
        for (int ml = 0; ml < 8; ml++)
          for (int sp = 0; sp < 2; sp++)
            for (int sl = 0; sl < 8; sl++)
              doAck(mp[0], ml[2:0], sp[0], sl[2:0]);
    end

    // R7: acknowledge held for three cycles
    @(negedge clk);
    mstPending = 1; mstLine = 3'd5; slvPending = 0; cpuAck = 1;
    @(negedge clk);
    chk("R7 first served", 32'(vectorValid), 1);
    @(negedge clk);
    chk("R7 busy ack dropped valid", 32'(vectorValid), 0);
    chk("R7 busy ack dropped strobe", 32'(mstAckStb), 0);
    @(negedge clk);
    cpuAck = 0;
    chk("R7 third served", 32'(vectorValid), 1);
    chk("R7 third vector", 32'(vector), 32'({mstBase, 3'd5}));
    @(negedge clk);

    // R8: trigger-mode register sweep
    for (int s = 0; s < 2; s++)
      for (int d = 0; d < 256; d++) begin
        logic [7:0] otherBefore;
        @(negedge clk);
        otherBefore = s ? mstTrigMode : slvTrigMode;
        cfgWrEn = 1; cfgSel = s[0]; cfgData = d[7:0];
        @(negedge clk);
        cfgWrEn = 0;
        if (s == 0) begin
          chk("R8 master mask", 32'(mstTrigMode), 32'(d[7:0] & 8'hF8));
          chk("R8 slave kept", 32'(slvTrigMode), 32'(otherBefore));
        end else begin
          chk("R8 slave mask", 32'(slvTrigMode), 32'(d[7:0] & 8'hDE));
          chk("R8 master kept", 32'(mstTrigMode), 32'(otherBefore));
        end
      end

    // R9: poll clear strobe
    @(negedge clk);
    pollSlvHit = 1;
    @(negedge clk);
    pollSlvHit = 0;
    chk("R9 clear high", 32'(mstCascadeClr), 1);
    @(negedge clk);
    chk("R9 clear low", 32'(mstCascadeClr), 0);

    // Same-cycle acknowledge, register write and poll (R3, R8, R9)
    @(negedge clk);
    mstPending = 1; mstLine = 3'd2; slvPending = 1; slvLine = 3'd6; cpuAck = 1;
    cfgWrEn = 1; cfgSel = 0; cfgData = 8'hFF; pollSlvHit = 1;
    @(negedge clk);
    cpuAck = 0; cfgWrEn = 0; pollSlvHit = 0;
    chk("R3 concurrent vector", 32'(vector), 32'({slvBase, 3'd6}));
    chk("R3 concurrent strobes", 32'({mstAckStb, slvAckStb}), 32'(2'b11));
    chk("R8 concurrent write", 32'(mstTrigMode), 32'h0F8);
    chk("R9 concurrent clear", 32'(mstCascadeClr), 1);
    @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule